// File: doc/BRIEF.md
# Configuration DMA Command Queue

This block is the register-programmed front end of a DMA engine that carries a configuration bitstream from memory into a configuration port. Software first writes a key to an unlock register. It then describes each transfer by writing four staging registers in a fixed order: source address, destination address, source length and destination length. The last of these writes turns the staged values into one command in a small in-order queue.

A dispatcher takes commands from the queue one at a time and hands each to an external transfer engine through a valid/ready handshake. It then waits for the engine to report completion and emits one-cycle event pulses. Two flags travel with each command. Bit 0 of the source address marks the last chunk of a bitstream, and the completion of that chunk is held back until the configuration port reports that it has finished. An all-ones destination address means that the data has no memory destination.

Top module: `cfgdma_cmdq`

## Requirements
- R1: After reset the block is locked and ignores every register write except a write of 0x757BDF0D to offset 0x034. Once that write is seen, the block stays unlocked until reset. Any other value written to 0x034 leaves it locked.
- R2: A command is formed only from the write sequence 0x018 (source address), 0x01C (destination address), 0x020 (source length) and 0x024 (destination length), in that order. A write to 0x018 always starts a new sequence. A write to 0x01C, 0x020 or 0x024 out of turn is discarded and cancels the sequence in progress.
- R3: Lengths are word counts taken from the low 27 bits of the written data. If the staged source length is 0 when the destination-length write completes the sequence, evt_cmd_err pulses for one cycle after that write and nothing is queued.
- R4: The queue holds 4 commands. A completed sequence that arrives while 4 commands are waiting is dropped, and evt_q_overflow pulses for one cycle after the write.
- R5: status_word reports queue full on bit 31 and queue empty on bit 30, and all other bits read 0. Both bits are updated in the cycle after a push or a pop.
- R6: Commands are offered on the cmd_* outputs strictly in the order they were accepted. cmd_valid is high only while no command is in flight and the queue is not empty. The offered fields hold steady until cmd_ready is seen.
- R7: For a command whose source address bit 0 is 0, evt_dma_done pulses for one cycle in the cycle after eng_done is seen while that command is in flight. The block then becomes ready to offer the next command.
- R8: For a command whose source address bit 0 is 1 (cmd_last high), eng_done does not complete it. Completion waits for cfg_port_done, and evt_dma_done and evt_cfg_done then pulse together in the following cycle.
- R9: cmd_no_dst is high for an offered command whose destination address is 0xFFFFFFFF. The address and both lengths are passed through unchanged.
- R10: Reset leaves the queue empty (status_word = 0x40000000), cmd_valid low and all event outputs low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| status_word | output | 32 | Queue full (bit 31) and empty (bit 30) |
| cmd_valid | output | 1 | A command is offered to the engine |
| cmd_ready | input | 1 | Engine accepts the offered command |
| cmd_src_addr | output | 32 | Source address of the offered command |
| cmd_dst_addr | output | 32 | Destination address of the offered command |
| cmd_src_len | output | 27 | Source length in words |
| cmd_dst_len | output | 27 | Destination length in words |
| cmd_last | output | 1 | Last chunk: wait for configuration port |
| cmd_no_dst | output | 1 | Command has no memory destination |
| eng_done | input | 1 | Engine finished the command in flight |
| cfg_port_done | input | 1 | Configuration port finished the bitstream |
| evt_dma_done | output | 1 | Pulse: a command completed |
| evt_cfg_done | output | 1 | Pulse: configuration completed |
| evt_cmd_err | output | 1 | Pulse: zero-length command rejected |
| evt_q_overflow | output | 1 | Pulse: push dropped on a full queue |

## Verification
The bench goes after the following corner cases:

- **Writes while locked.** A design that let writes through before the key, or that accepted a wrong key, would show a non-empty queue after a locked sequence.
- **Out-of-turn writes and restarts.** Skipping the destination address, or restarting with a new source address, must not produce a command. A design that pushed on any destination-length write would queue phantom commands.
- **Simultaneous pop and push on a full queue.** The push is judged against the occupancy before the pop, so the command is dropped with an overflow pulse. A design that used the occupancy after the pop would silently accept it.
- **Last-chunk and no-destination commands.** A design that ignored bit 0 would report completion on eng_done and would never pair evt_cfg_done with evt_dma_done. A dispatcher that did not hold the command in flight would offer a second command early.

// File: rtl/cfgdma_pkg.sv
package cfgdma_pkg;

   localparam int ADDR_W    = 32;
   localparam int LEN_W     = 27;
   localparam int FULL_BIT  = 31;
   localparam int EMPTY_BIT = 30;

   typedef struct packed {
      logic [ADDR_W-1:0] src_addr;
      logic [ADDR_W-1:0] dst_addr;
      logic [LEN_W-1:0]  src_len;
      logic [LEN_W-1:0]  dst_len;
   } cmd_t;

   localparam int CMD_W = $bits(cmd_t);

   typedef enum logic [1:0] {
      WANT_SRC  = 2'd0,
      WANT_DST  = 2'd1,
      WANT_SLEN = 2'd2,
      WANT_DLEN = 2'd3
   } step_e;

   typedef enum logic [1:0] {
      SQ_IDLE = 2'd0,
      SQ_RUN  = 2'd1,
      SQ_HOLD = 2'd2
   } sq_state_e;

endpackage

// File: rtl/cfgdma_regfile.sv
module cfgdma_regfile
   import cfgdma_pkg::*;
#(
   parameter int                REG_AW     = 12,
   parameter logic [REG_AW-1:0] OFS_SRC    = 12'h018,
   parameter logic [REG_AW-1:0] OFS_DST    = 12'h01C,
   parameter logic [REG_AW-1:0] OFS_SLEN   = 12'h020,
   parameter logic [REG_AW-1:0] OFS_DLEN   = 12'h024,
   parameter logic [REG_AW-1:0] OFS_UNLK   = 12'h034,
   parameter logic [31:0]       UNLOCK_KEY = 32'h757B_DF0D
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [REG_AW-1:0] wr_addr,
   input  logic [31:0]       wr_data,
   output logic              push_req,
   output cmd_t              push_cmd
);

   logic              unlocked;
   step_e             step;
   logic [ADDR_W-1:0] stg_src;
   logic [ADDR_W-1:0] stg_dst;
   logic [LEN_W-1:0]  stg_slen;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         unlocked <= 1'b0;
         step     <= WANT_SRC;
         stg_src  <= '0;
         stg_dst  <= '0;
         stg_slen <= '0;
      end else if (wr_en) begin
         if (!unlocked) begin
            if (wr_addr == OFS_UNLK && wr_data == UNLOCK_KEY) unlocked <= 1'b1;
         end else begin
            case (wr_addr)
               OFS_SRC: begin
                  stg_src <= wr_data;
                  step    <= WANT_DST;
               end
               OFS_DST: begin
                  if (step == WANT_DST) begin
                     stg_dst <= wr_data;
                     step    <= WANT_SLEN;
                  end else begin
                     step <= WANT_SRC;
                  end
               end
               OFS_SLEN: begin
                  if (step == WANT_SLEN) begin
                     stg_slen <= wr_data[LEN_W-1:0];
                     step     <= WANT_DLEN;
                  end else begin
                     step <= WANT_SRC;
                  end
               end
               OFS_DLEN: step <= WANT_SRC;
               default:  ;
            endcase
         end
      end
   end

   always_comb begin
      push_req          = wr_en && unlocked && (wr_addr == OFS_DLEN) && (step == WANT_DLEN);
      push_cmd.src_addr = stg_src;
      push_cmd.dst_addr = stg_dst;
      push_cmd.src_len  = stg_slen;
      push_cmd.dst_len  = wr_data[LEN_W-1:0];
   end

   // R1: the unlock state never falls back while out of reset
   p_unlock_sticky_r1: assert property (@(posedge clk) disable iff (!rst_n)
      unlocked |=> unlocked);

   // R1: the block unlocks only on the key written to the unlock offset
   p_unlock_cause_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(unlocked) |-> $past(wr_en && wr_addr == OFS_UNLK && wr_data == UNLOCK_KEY));

endmodule

// File: rtl/cfgdma_fifo.sv
module cfgdma_fifo #(
   parameter int W     = 8,
   parameter int DEPTH = 4
)(
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic         pop,
   input  logic [W-1:0] din,
   output logic [W-1:0] dout,
   output logic         full,
   output logic         empty
);

   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CNT_W = $clog2(DEPTH + 1);
   localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(DEPTH - 1);

   logic [W-1:0]     mem [DEPTH];
   logic [PTR_W-1:0] wr_ptr, rd_ptr, wr_nxt, rd_nxt;
   logic [CNT_W-1:0] count;

   generate
      if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2_wrap
         assign wr_nxt = wr_ptr + 1'b1;
         assign rd_nxt = rd_ptr + 1'b1;
      end else begin : g_cmp_wrap
         assign wr_nxt = (wr_ptr == LAST_IDX) ? '0 : wr_ptr + 1'b1;
         assign rd_nxt = (rd_ptr == LAST_IDX) ? '0 : rd_ptr + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (push) wr_ptr <= wr_nxt;
         if (pop)  rd_ptr <= rd_nxt;
         if (push && !pop)      count <= count + 1'b1;
         else if (pop && !push) count <= count - 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (push) mem[wr_ptr] <= din;
   end

   assign dout  = mem[rd_ptr];
   assign full  = (count == CNT_W'(DEPTH));
   assign empty = (count == '0);

   // R4: occupancy never exceeds the queue depth
   p_count_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CNT_W'(DEPTH));

   // R4: the caller never pushes into a full queue
   p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> !full);

   // R5: full and empty never hold together
   p_full_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !(full && empty));

endmodule

// File: rtl/cfgdma_sequencer.sv
module cfgdma_sequencer
   import cfgdma_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic head_valid,
   input  logic head_last,
   input  logic cmd_ready,
   input  logic eng_done,
   input  logic cfg_port_done,
   output logic issue,
   output logic pop,
   output logic evt_dma_done,
   output logic evt_cfg_done
);

   sq_state_e state;

   assign issue = (state == SQ_IDLE) && head_valid;
   assign pop   = issue && cmd_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state        <= SQ_IDLE;
         evt_dma_done <= 1'b0;
         evt_cfg_done <= 1'b0;
      end else begin
         evt_dma_done <= 1'b0;
         evt_cfg_done <= 1'b0;
         case (state)
            SQ_IDLE: if (pop) state <= head_last ? SQ_HOLD : SQ_RUN;
            SQ_RUN:  if (eng_done) begin
                        state        <= SQ_IDLE;
                        evt_dma_done <= 1'b1;
                     end
            SQ_HOLD: if (cfg_port_done) begin
                        state        <= SQ_IDLE;
                        evt_dma_done <= 1'b1;
                        evt_cfg_done <= 1'b1;
                     end
            default: state <= SQ_IDLE;
         endcase
      end
   end

   // R7: a completion pulse always follows an engine or port report
   p_done_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
      evt_dma_done |-> $past(eng_done || cfg_port_done));

   // R8: configuration done is always paired with a DMA done
   p_cfg_pair_r8: assert property (@(posedge clk) disable iff (!rst_n)
      evt_cfg_done |-> evt_dma_done);

endmodule

// File: rtl/cfgdma_cmdq.sv
module cfgdma_cmdq
   import cfgdma_pkg::*;
#(
   parameter int                DEPTH      = 4,
   parameter int                REG_AW     = 12,
   parameter logic [REG_AW-1:0] OFS_SRC    = 12'h018,
   parameter logic [REG_AW-1:0] OFS_DST    = 12'h01C,
   parameter logic [REG_AW-1:0] OFS_SLEN   = 12'h020,
   parameter logic [REG_AW-1:0] OFS_DLEN   = 12'h024,
   parameter logic [REG_AW-1:0] OFS_UNLK   = 12'h034,
   parameter logic [31:0]       UNLOCK_KEY = 32'h757B_DF0D
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       status_word,
   output logic              cmd_valid,
   input  logic              cmd_ready,
   output logic [ADDR_W-1:0] cmd_src_addr,
   output logic [ADDR_W-1:0] cmd_dst_addr,
   output logic [LEN_W-1:0]  cmd_src_len,
   output logic [LEN_W-1:0]  cmd_dst_len,
   output logic              cmd_last,
   output logic              cmd_no_dst,
   input  logic              eng_done,
   input  logic              cfg_port_done,
   output logic              evt_dma_done,
   output logic              evt_cfg_done,
   output logic              evt_cmd_err,
   output logic              evt_q_overflow
);

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("cfgdma_cmdq: DEPTH must be at least 2");
      end
      if (REG_AW < 6) begin : g_bad_aw
         $error("cfgdma_cmdq: REG_AW too narrow for the register offsets");
      end
      if (OFS_SRC == OFS_DST || OFS_DST == OFS_SLEN || OFS_SLEN == OFS_DLEN) begin : g_bad_ofs
         $error("cfgdma_cmdq: sequence offsets must be distinct");
      end
   endgenerate

   logic push_req, accept, q_full, q_empty, pop;
   cmd_t push_cmd, head;
   logic [CMD_W-1:0] head_bits;

   cfgdma_regfile #(
      .REG_AW(REG_AW), .OFS_SRC(OFS_SRC), .OFS_DST(OFS_DST), .OFS_SLEN(OFS_SLEN),
      .OFS_DLEN(OFS_DLEN), .OFS_UNLK(OFS_UNLK), .UNLOCK_KEY(UNLOCK_KEY)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .wr_addr(reg_addr),
      .wr_data(reg_wdata), .push_req(push_req), .push_cmd(push_cmd)
   );

   assign accept = push_req && (push_cmd.src_len != '0) && !q_full;

   cfgdma_fifo #(.W(CMD_W), .DEPTH(DEPTH)) u_fifo (
      .clk(clk), .rst_n(rst_n), .push(accept), .pop(pop),
      .din(push_cmd), .dout(head_bits), .full(q_full), .empty(q_empty)
   );

   assign head = cmd_t'(head_bits);

   cfgdma_sequencer u_seq (
      .clk(clk), .rst_n(rst_n), .head_valid(!q_empty), .head_last(head.src_addr[0]),
      .cmd_ready(cmd_ready), .eng_done(eng_done), .cfg_port_done(cfg_port_done),
      .issue(cmd_valid), .pop(pop),
      .evt_dma_done(evt_dma_done), .evt_cfg_done(evt_cfg_done)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         evt_cmd_err    <= 1'b0;
         evt_q_overflow <= 1'b0;
      end else begin
         evt_cmd_err    <= push_req && (push_cmd.src_len == '0);
         evt_q_overflow <= push_req && (push_cmd.src_len != '0) && q_full;
      end
   end

   always_comb begin
      status_word            = '0;
      status_word[FULL_BIT]  = q_full;
      status_word[EMPTY_BIT] = q_empty;
   end

   assign cmd_src_addr = head.src_addr;
   assign cmd_dst_addr = head.dst_addr;
   assign cmd_src_len  = head.src_len;
   assign cmd_dst_len  = head.dst_len;
   assign cmd_last     = head.src_addr[0];
   assign cmd_no_dst   = (head.dst_addr == '1);

   // R6: an offered command stays put until the engine takes it
   p_offer_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_src_addr) && $stable(cmd_src_len));

   // R3: a rejected command never coincides with an overflow report
   p_err_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !(evt_cmd_err && evt_q_overflow));

endmodule

// File: tb/cfgdma_cmdq_tb.sv
`timescale 1ns/1ps
module cfgdma_cmdq_tb;
   import cfgdma_pkg::*;

   localparam logic [31:0] KEY = 32'h757B_DF0D;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [11:0] reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic        cmd_ready = 1'b0, eng_done = 1'b0, cfg_port_done = 1'b0;
   logic [31:0] status_word;
   logic        cmd_valid, cmd_last, cmd_no_dst;
   logic [31:0] cmd_src_addr, cmd_dst_addr;
   logic [26:0] cmd_src_len, cmd_dst_len;
   logic        evt_dma_done, evt_cfg_done, evt_cmd_err, evt_q_overflow;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   cfgdma_cmdq u_dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .status_word(status_word), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
      .cmd_src_addr(cmd_src_addr), .cmd_dst_addr(cmd_dst_addr),
      .cmd_src_len(cmd_src_len), .cmd_dst_len(cmd_dst_len),
      .cmd_last(cmd_last), .cmd_no_dst(cmd_no_dst),
      .eng_done(eng_done), .cfg_port_done(cfg_port_done),
      .evt_dma_done(evt_dma_done), .evt_cfg_done(evt_cfg_done),
      .evt_cmd_err(evt_cmd_err), .evt_q_overflow(evt_q_overflow)
   );

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   cmd_t        m_q[$];
   bit          m_unl;
   int          m_step;
   int          m_state;
   bit          m_last;
   logic [31:0] s_src, s_dst;
   logic [26:0] s_slen;
   bit          e_dma, e_cfg, e_err, e_ovf;

   always @(posedge clk or negedge rst_n) begin : model
      int   sz0;
      int   st0;
      cmd_t c;
      if (!rst_n) begin
         m_q.delete();
         m_unl = 0; m_step = 0; m_state = 0; m_last = 0;
         s_src = '0; s_dst = '0; s_slen = '0;
         e_dma = 0; e_cfg = 0; e_err = 0; e_ovf = 0;
      end else begin
         sz0 = m_q.size();
         st0 = m_state;
         e_dma = 0; e_cfg = 0; e_err = 0; e_ovf = 0;
         if (st0 == 0) begin
            if (sz0 > 0 && cmd_ready) begin
               m_last = m_q[0].src_addr[0];
               void'(m_q.pop_front());
               m_state = m_last ? 2 : 1;
            end
         end else if (st0 == 1) begin
            if (eng_done) begin m_state = 0; e_dma = 1; end
         end else begin
            if (cfg_port_done) begin m_state = 0; e_dma = 1; e_cfg = 1; end
         end
         if (reg_wr) begin
            if (!m_unl) begin
               if (reg_addr == 12'h034 && reg_wdata == KEY) m_unl = 1;
            end else begin
               case (reg_addr)
                  12'h018: begin s_src = reg_wdata; m_step = 1; end
                  12'h01C: if (m_step == 1) begin s_dst = reg_wdata; m_step = 2; end else m_step = 0;
                  12'h020: if (m_step == 2) begin s_slen = reg_wdata[26:0]; m_step = 3; end else m_step = 0;
                  12'h024: begin
                     if (m_step == 3) begin
                        if (s_slen == 0) e_err = 1;
                        else if (sz0 == 4) e_ovf = 1;
                        else begin
                           c.src_addr = s_src; c.dst_addr = s_dst;
                           c.src_len = s_slen; c.dst_len = reg_wdata[26:0];
                           m_q.push_back(c);
                        end
                     end
                     m_step = 0;
                  end
                  default: ;
               endcase
            end
         end
      end
   end

   // ---------------- per-cycle comparison ----------------
   always @(negedge clk) begin : compare
      logic [31:0] exp_stat;
      bit          exp_valid;
      if (rst_n && !finished) begin
         exp_stat = {m_q.size() == 4, m_q.size() == 0, 30'b0};
         chk(status_word === exp_stat, "R5 status", 64'(status_word), 64'(exp_stat));
         exp_valid = (m_state == 0) && (m_q.size() > 0);
         chk(cmd_valid === exp_valid, "R6 cmd_valid", 64'(cmd_valid), 64'(exp_valid));
         if (exp_valid && cmd_valid) begin
            chk(cmd_src_addr === m_q[0].src_addr, "R6 src_addr", 64'(cmd_src_addr), 64'(m_q[0].src_addr));
            chk(cmd_dst_addr === m_q[0].dst_addr, "R9 dst_addr", 64'(cmd_dst_addr), 64'(m_q[0].dst_addr));
            chk(cmd_src_len === m_q[0].src_len, "R6 src_len", 64'(cmd_src_len), 64'(m_q[0].src_len));
            chk(cmd_dst_len === m_q[0].dst_len, "R9 dst_len", 64'(cmd_dst_len), 64'(m_q[0].dst_len));
            chk(cmd_no_dst === (m_q[0].dst_addr == 32'hFFFF_FFFF), "R9 no_dst",
                64'(cmd_no_dst), 64'(m_q[0].dst_addr == 32'hFFFF_FFFF));
            chk(cmd_last === m_q[0].src_addr[0], "R8 last flag", 64'(cmd_last), 64'(m_q[0].src_addr[0]));
         end
         chk(evt_dma_done === e_dma, "R7 dma_done", 64'(evt_dma_done), 64'(e_dma));
         chk(evt_cfg_done === e_cfg, "R8 cfg_done", 64'(evt_cfg_done), 64'(e_cfg));
         chk(evt_cmd_err === e_err, "R3 cmd_err", 64'(evt_cmd_err), 64'(e_err));
         chk(evt_q_overflow === e_ovf, "R4 overflow", 64'(evt_q_overflow), 64'(e_ovf));
      end
   end

   // ---------------- stimulus ----------------
   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic seq(input logic [31:0] src, input logic [31:0] dst,
                      input logic [31:0] sl, input logic [31:0] dl);
      wr(12'h018, src); wr(12'h01C, dst); wr(12'h020, sl); wr(12'h024, dl);
   endtask

   initial begin : main
      logic [31:0] r, d;
      int          nxt;
      logic [11:0] a;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R10: reset state
      chk(status_word === 32'h4000_0000, "R10 reset status", 64'(status_word), 64'h4000_0000);
      chk(cmd_valid === 1'b0, "R10 reset cmd_valid", 64'(cmd_valid), 64'h0);
      chk({evt_dma_done, evt_cfg_done, evt_cmd_err, evt_q_overflow} === 4'b0, "R10 reset events",
          64'({evt_dma_done, evt_cfg_done, evt_cmd_err, evt_q_overflow}), 64'h0);

      // R1: locked writes and a wrong key have no effect
      seq(32'h1000_0000, 32'hFFFF_FFFF, 32'd8, 32'd0);
      chk(status_word === 32'h4000_0000, "R1 locked sequence ignored", 64'(status_word), 64'h4000_0000);
      wr(12'h034, 32'h1234_5678);
      seq(32'h1000_0000, 32'hFFFF_FFFF, 32'd8, 32'd0);
      chk(status_word === 32'h4000_0000, "R1 wrong key ignored", 64'(status_word), 64'h4000_0000);
      wr(12'h034, KEY);

      // R2: out-of-turn writes cancel the sequence
      wr(12'h018, 32'h2000_0000); wr(12'h020, 32'd4); wr(12'h01C, 32'h0); wr(12'h024, 32'd0);
      chk(status_word === 32'h4000_0000, "R2 out-of-turn no push", 64'(status_word), 64'h4000_0000);
      wr(12'h018, 32'h2000_0000); wr(12'h01C, 32'h0); wr(12'h018, 32'h2100_0000); wr(12'h020, 32'd4);
      wr(12'h024, 32'd0);
      chk(status_word === 32'h4000_0000, "R2 restart then skip no push", 64'(status_word), 64'h4000_0000);

      // R4/R5: fill with the engine stalled, then overflow; R3 zero length
      seq(32'h3000_0000, 32'hFFFF_FFFF, 32'd16, 32'd0);
      seq(32'h3000_1000, 32'h4000_0000, 32'h0800_0003, 32'd3);
      seq(32'h3000_2001, 32'hFFFF_FFFF, 32'd1, 32'd0);
      seq(32'h3000_3000, 32'h5000_0000, 32'h07FF_FFFF, 32'h07FF_FFFF);
      chk(status_word === 32'h8000_0000, "R5 full after four pushes", 64'(status_word), 64'h8000_0000);
      seq(32'h3000_4000, 32'h0, 32'd2, 32'd0);
      seq(32'h3000_5000, 32'h0, 32'h0800_0000, 32'd0);

      // R7/R8: drain in order with engine responses
      cmd_ready = 1'b1;
      repeat (6) begin
         @(negedge clk); eng_done = 1'b1;
         @(negedge clk); eng_done = 1'b0; cfg_port_done = 1'b1;
         @(negedge clk); cfg_port_done = 1'b0;
      end
      chk(status_word === 32'h4000_0000, "R6 drained", 64'(status_word), 64'h4000_0000);
      seq(32'h3100_0000, 32'h0, 32'd0, 32'd5);

      // mixed random phase
      nxt = 0;
      for (int i = 0; i < 4000; i++) begin
         @(negedge clk);
         r = $urandom;
         d = $urandom;
         cmd_ready     = r[8] | r[9];
         eng_done      = r[10] & r[11];
         cfg_port_done = r[12] & r[13] & r[14];
         reg_wr        = r[0] | r[1];
         case (r[4:2])
            3'd4:    a = 12'h018 + 12'(4 * (r[6:5]));
            3'd5:    begin a = 12'h034; d = r[7] ? KEY : d; end
            3'd6:    a = 12'h014;
            default: a = 12'h018 + 12'(4 * nxt);
         endcase
         if ((a == 12'h020 || a == 12'h024) && r[15]) d = {d[31:27], 22'd0, d[4:0]};
         if (a == 12'h020 && r[16] && r[17]) d = 32'h0;
         if (a == 12'h01C && r[18]) d = 32'hFFFF_FFFF;
         reg_addr  = a;
         reg_wdata = d;
         if (reg_wr && a >= 12'h018 && a <= 12'h024) nxt = (int'((a - 12'h018) >> 2) + 1) % 4;
      end
      @(negedge clk);
      reg_wr = 1'b0; cmd_ready = 1'b1; eng_done = 1'b1; cfg_port_done = 1'b1;
      repeat (20) @(negedge clk);
      chk(status_word === 32'h4000_0000, "R6 final drain", 64'(status_word), 64'h4000_0000);
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin : watchdog
      #(5.0 * 150000);
      if (!finished) begin
         finished = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule